// File: doc/BRIEF.md
# Banked Pending Interrupt Resolver

This block picks the next interrupt to service in a controller whose sources are grouped in three pending words. The first is a 21-bit summary word: eight directly owned sources, two "bank has more" summary bits and eleven mirror bits. The mirror bits repeat selected sources of the two 32-bit banks, so that they can be found without reading the bank. The other two inputs are the full 32-bit bank words. The block returns the flat number of one source and a valid flag. The numbering is direct sources 0 to 7, bank A 8 to 39 and bank B 40 to 71.

The search is not plain lowest-bit-first. Direct sources win first. The mirrored bank sources come next, in a fixed list. The full bank words are scanned last, with their mirrored bits removed. A bank word is scanned only when its summary bit in the summary word is set. The result is registered, so it appears one clock after the inputs are sampled.

Top module: `pend_resolver`

## Requirements
- R1: When the whole 21-bit summary word is zero, irq_vld is low regardless of the bank words.
- R2: When any of summary bits 0 to 7 is set, the result is the index of the lowest set bit among them.
- R3: Otherwise, summary bits 10..14 mirror bank A bits 7, 9, 10, 18, 19 in that order, and the first set bit in that order returns 8 plus the bank A bit position.
- R4: Otherwise, summary bits 15..20 mirror bank B bits 21, 22, 23, 24, 25, 30 in that order, and the first set bit in that order returns 40 plus the bank B bit position.
- R5: Otherwise, if summary bit 8 is set, bank A is scanned with bits 7, 9, 10, 18, 19 masked off, and the lowest remaining set bit b returns 8+b.
- R6: Otherwise, if summary bit 9 is set, bank B is scanned with bits 21 to 25 and 30 masked off, and the lowest remaining set bit b returns 40+b.
- R7: When a summary bit is set but its masked bank word is empty and nothing else qualifies, irq_vld is low.
- R8: A bank word has no effect on the result while its summary bit (8 for bank A, 9 for bank B) is clear.
- R9: Outputs are registered. Reset drives irq_vld low and irq_num to zero. The result for inputs sampled at one rising edge appears after that edge, and it stays stable while the inputs stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| basic_pend | input | 21 | Summary word: direct sources, bank summaries, mirrors |
| bank1_pend | input | 32 | Bank A pending word |
| bank2_pend | input | 32 | Bank B pending word |
| irq_num | output | 7 | Flat number of the selected source |
| irq_vld | output | 1 | A source was selected |

## Verification
The assertions that tie a returned bank number to its bank word assume that the inputs are coherent. A mirror bit is set only when its bank bit is pending. They do not assume that a summary bit implies a non-empty masked bank, so that case is left free. The bench builds every summary word from the bank words it drives, setting the mirrors from the listed bank bits and the summary bits from the remaining ones. It then breaks coherence only toward a summary bit with an empty bank, or toward a bank with its summary bit clear, which are the cases R7 and R8 describe.

// File: rtl/pend_resolver_pkg.sv
package pend_resolver_pkg;
  localparam int DIRECT_W = 8;
  localparam int BANK_W   = 32;
  localparam int BASIC_W  = 21;
  localparam int NUM_W    = 7;
  localparam int POS_W    = 5;
  localparam int NBANK    = 2;

  // summary word layout
  localparam int SUM_BIT0  = 8;   // bank A summary, bank B at +1
  localparam int MIR1_LSB  = 10;
  localparam int MIR1_N    = 5;
  localparam int MIR2_LSB  = MIR1_LSB + MIR1_N;
  localparam int MIR2_N    = 6;

  localparam int BASE1 = DIRECT_W;
  localparam int BASE2 = DIRECT_W + BANK_W;

  // mirror lists, entry 0 in the low field = searched first
  localparam logic [MIR1_N*POS_W-1:0] MIR1_POS =
    {5'd19, 5'd18, 5'd10, 5'd9, 5'd7};
  localparam logic [MIR2_N*POS_W-1:0] MIR2_POS =
    {5'd30, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21};

  function automatic logic [BANK_W-1:0] list_mask(
      input logic [MIR2_N*POS_W-1:0] pos, input int n);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[pos[i*POS_W +: POS_W]] = 1'b1;
    return m;
  endfunction

  localparam logic [BANK_W-1:0] MIR1_MASK =
    list_mask((MIR2_N*POS_W)'(MIR1_POS), MIR1_N);
  localparam logic [BANK_W-1:0] MIR2_MASK = list_mask(MIR2_POS, MIR2_N);
endpackage

// File: rtl/prs_lsb_find.sv
module prs_lsb_find #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/prs_mirror_pick.sv
module prs_mirror_pick
  import pend_resolver_pkg::*;
#(
  parameter int                  N   = 5,
  parameter logic [N*POS_W-1:0]  POS = '0
) (
  input  logic [N-1:0]     mir,
  output logic             hit,
  output logic [POS_W-1:0] pos
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  logic [IW-1:0] first;

  prs_lsb_find #(.W(N), .IDX_W(IW)) u_first (
    .vec(mir), .found(hit), .idx(first)
  );

  always_comb begin
    pos = '0;
    for (int i = 0; i < N; i++) begin
      if (first == IW'(i)) pos = POS[i*POS_W +: POS_W];
    end
  end
endmodule

// File: rtl/pend_resolver.sv
module pend_resolver
  import pend_resolver_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BASIC_W-1:0] basic_pend,
  input  logic [BANK_W-1:0]  bank1_pend,
  input  logic [BANK_W-1:0]  bank2_pend,
  output logic [NUM_W-1:0]   irq_num,
  output logic               irq_vld
);
  localparam int DIDX_W = $clog2(DIRECT_W);
  localparam int BIDX_W = $clog2(BANK_W);
  localparam logic [NBANK*BANK_W-1:0] MASKS = {MIR2_MASK, MIR1_MASK};
  localparam logic [NBANK*NUM_W-1:0]  BASES = {NUM_W'(BASE2), NUM_W'(BASE1)};

  logic                 dir_hit;
  logic [DIDX_W-1:0]    dir_idx;
  logic                 m1_hit, m2_hit;
  logic [POS_W-1:0]     m1_pos, m2_pos;
  logic [NBANK*BANK_W-1:0] bank_all;
  logic [NBANK-1:0]     bk_hit;
  logic [NBANK*BIDX_W-1:0] bk_idx;
  logic [NUM_W-1:0]     num_d, num_q;
  logic                 vld_d, vld_q;

  assign bank_all = {bank2_pend, bank1_pend};

  prs_lsb_find #(.W(DIRECT_W), .IDX_W(DIDX_W)) u_direct (
    .vec(basic_pend[DIRECT_W-1:0]), .found(dir_hit), .idx(dir_idx)
  );

  prs_mirror_pick #(.N(MIR1_N), .POS(MIR1_POS)) u_mir1 (
    .mir(basic_pend[MIR1_LSB +: MIR1_N]), .hit(m1_hit), .pos(m1_pos)
  );

  prs_mirror_pick #(.N(MIR2_N), .POS(MIR2_POS)) u_mir2 (
    .mir(basic_pend[MIR2_LSB +: MIR2_N]), .hit(m2_hit), .pos(m2_pos)
  );

  // full bank scans, mirrored bits removed, gated by the summary bit
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [BANK_W-1:0] masked;
    logic              fnd;
    assign masked = bank_all[g*BANK_W +: BANK_W] & ~MASKS[g*BANK_W +: BANK_W];
    prs_lsb_find #(.W(BANK_W), .IDX_W(BIDX_W)) u_scan (
      .vec(masked), .found(fnd), .idx(bk_idx[g*BIDX_W +: BIDX_W])
    );
    assign bk_hit[g] = fnd & basic_pend[SUM_BIT0 + g];
  end

  // next-state selection in fixed priority
  always_comb begin
    num_d = '0;
    vld_d = 1'b1;
    if (basic_pend == '0) begin
      vld_d = 1'b0;
    end else if (dir_hit) begin
      num_d = NUM_W'(dir_idx);
    end else if (m1_hit) begin
      num_d = NUM_W'(BASE1) + NUM_W'(m1_pos);
    end else if (m2_hit) begin
      num_d = NUM_W'(BASE2) + NUM_W'(m2_pos);
    end else if (bk_hit[0]) begin
      num_d = BASES[0 +: NUM_W] + NUM_W'(bk_idx[0 +: BIDX_W]);
    end else if (bk_hit[1]) begin
      num_d = BASES[NUM_W +: NUM_W] + NUM_W'(bk_idx[BIDX_W +: BIDX_W]);
    end else begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= '0;
      vld_q <= 1'b0;
    end else begin
      num_q <= num_d;
      vld_q <= vld_d;
    end
  end

  assign irq_num = num_q;
  assign irq_vld = vld_q;

  // ---------------- assertions ----------------
  logic arm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= 1'b1;
  end

  // R1
  idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (basic_pend == '0) |=> !irq_vld);

  // R2
  direct_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (basic_pend[DIRECT_W-1:0] != '0) |=> (irq_vld && irq_num < NUM_W'(DIRECT_W)));

  // R3
  bank1_src_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vld && irq_num >= NUM_W'(BASE1) && irq_num < NUM_W'(BASE2)) |->
      (|($past(bank1_pend) & (32'd1 << (irq_num - NUM_W'(BASE1))))));

  // R4
  bank2_src_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vld && irq_num >= NUM_W'(BASE2)) |->
      (|($past(bank2_pend) & (32'd1 << (irq_num - NUM_W'(BASE2))))));

  // R3
  mirror_before_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (basic_pend[DIRECT_W-1:0] == '0 && basic_pend[MIR1_LSB +: MIR1_N] != '0) |=>
      (irq_vld && irq_num >= NUM_W'(BASE1) && irq_num < NUM_W'(BASE2)));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && $stable(basic_pend) && $stable(bank1_pend) && $stable(bank2_pend))
      |=> ($stable(irq_num) && $stable(irq_vld)));
endmodule

// File: tb/pend_resolver_tb.sv
module pend_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [20:0] basic_pend;
  logic [31:0] bank1_pend, bank2_pend;
  logic [6:0]  irq_num;
  logic        irq_vld;
  int checks = 0;
  int errors = 0;
  int q1[$] = '{7, 9, 10, 18, 19};
  int q2[$] = '{21, 22, 23, 24, 25, 30};

  always #5 clk = ~clk;

  pend_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .basic_pend(basic_pend),
    .bank1_pend(bank1_pend), .bank2_pend(bank2_pend),
    .irq_num(irq_num), .irq_vld(irq_vld)
  );

  function automatic bit in_list(int b, int q[$]);
    foreach (q[k]) if (q[k] == b) return 1'b1;
    return 1'b0;
  endfunction

  // behavioural reference: -1 means nothing to service
  function automatic int ref_pick(logic [20:0] bw, logic [31:0] w1, logic [31:0] w2);
    if (bw == 0) return -1;
    for (int i = 0; i < 8; i++) if (bw[i]) return i;
    foreach (q1[k]) if (bw[10 + k]) return 8 + q1[k];
    foreach (q2[k]) if (bw[15 + k]) return 40 + q2[k];
    if (bw[8]) for (int b = 0; b < 32; b++) if (w1[b] && !in_list(b, q1)) return 8 + b;
    if (bw[9]) for (int b = 0; b < 32; b++) if (w2[b] && !in_list(b, q2)) return 40 + b;
    return -1;
  endfunction

  // coherent summary word from direct bits and bank words
  function automatic logic [20:0] mk_basic(logic [7:0] d, logic [31:0] w1, logic [31:0] w2);
    logic [20:0] bw;
    bw = '0;
    bw[7:0] = d;
    foreach (q1[k]) bw[10 + k] = w1[q1[k]];
    foreach (q2[k]) bw[15 + k] = w2[q2[k]];
    for (int b = 0; b < 32; b++) begin
      if (w1[b] && !in_list(b, q1)) bw[8] = 1'b1;
      if (w2[b] && !in_list(b, q2)) bw[9] = 1'b1;
    end
    return bw;
  endfunction

  task automatic compare(string req, int exp);
    checks++;
    if (exp < 0) begin
      if (irq_vld !== 1'b0) begin
        errors++;
        $display("FAIL %s: vld=%0b num=%0d expected vld=0", req, irq_vld, irq_num);
      end
    end else if (irq_vld !== 1'b1 || int'(irq_num) != exp) begin
      errors++;
      $display("FAIL %s: vld=%0b num=%0d expected vld=1 num=%0d", req, irq_vld, irq_num, exp);
    end
  endtask

  // drive at negedge, result captured at next posedge, sampled at next negedge
  task automatic step(string req, logic [20:0] bw, logic [31:0] w1, logic [31:0] w2);
    basic_pend = bw; bank1_pend = w1; bank2_pend = w2;
    @(negedge clk);
    compare(req, ref_pick(bw, w1, w2));
  endtask

  task automatic stepc(string req, logic [7:0] d, logic [31:0] w1, logic [31:0] w2);
    step(req, mk_basic(d, w1, w2), w1, w2);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    basic_pend = '1; bank1_pend = '1; bank2_pend = '1;
    repeat (3) @(negedge clk);
    // R9 reset state
    checks++;
    if (irq_vld !== 1'b0 || irq_num !== 7'd0) begin
      errors++;
      $display("FAIL R9 reset: vld=%0b num=%0d expected vld=0 num=0", irq_vld, irq_num);
    end
    rst_n = 1'b1;
    step("R1 idle", 21'd0, 32'd0, 32'd0);

    // single sources, all 72 numbers
    for (int n = 0; n < 8; n++) stepc("R2 single", 8'(1 << n), 32'd0, 32'd0);
    for (int b = 0; b < 32; b++)
      stepc(in_list(b, q1) ? "R3 single" : "R5 single", 8'd0, 32'd1 << b, 32'd0);
    for (int b = 0; b < 32; b++)
      stepc(in_list(b, q2) ? "R4 single" : "R6 single", 8'd0, 32'd0, 32'd1 << b);

    // priority among several sources
    stepc("R2 direct over banks", 8'h28, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    stepc("R3 list order", 8'd0, (32'd1 << 19) | (32'd1 << 9), 32'd0);
    stepc("R3 mirror over scan", 8'd0, (32'd1 << 12) | (32'd1 << 18), 32'd0);
    stepc("R3 bank A mirror over B mirror", 8'd0, 32'd1 << 10, 32'd1 << 21);
    stepc("R4 list order", 8'd0, 32'd0, (32'd1 << 30) | (32'd1 << 22));
    stepc("R4 B mirror over A scan", 8'd0, 32'd1 << 3, 32'd1 << 30);
    stepc("R5 lowest", 8'd0, (32'd1 << 20) | (32'd1 << 5), 32'd0);
    stepc("R5 A scan over B scan", 8'd0, 32'd1 << 31, 32'd1 << 0);
    stepc("R6 lowest", 8'd0, 32'd0, (32'd1 << 26) | (32'd1 << 3));
    // R7: summary set, bank empty after masking
    step("R7 empty A", 21'h00100, 32'd0, 32'd0);
    step("R7 empty B", 21'h00200, 32'd0, 32'd1 << 30);
    // R8: bank word ignored with summary clear
    step("R8 A ignored", mk_basic(8'd0, 32'd0, 32'd1), 32'd1 << 4, 32'd1);
    step("R8 B ignored", mk_basic(8'd0, 32'd1 << 6, 32'd0), 32'd1 << 6, 32'd1 << 2);
    step("R1 banks ignored", 21'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R9 hold: same inputs again, result unchanged
    stepc("R9 hold a", 8'd0, 32'd1 << 13, 32'd0);
    stepc("R9 hold b", 8'd0, 32'd1 << 13, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule